// File: doc/BRIEF.md
# Boot Link Poll Responder

This block sits on the target side of a single-wire serial boot link, between the UART byte strobes and the pin driver. After reset it keeps its transmit output passive, so nothing is driven onto the shared wire. It goes online only once the host has sent at least one byte. A host that is unsure whether the target has left reset can keep sending a one-byte enquiry, and the block answers each one with a single status byte. That lets the host poll while reset capacitors and supplies ramp, and it also catches a target that restarts on its own.

Errors reported by the neighbouring character decoder and command parser are never sent as free-running text. Each error strobe sets a sticky flag. The flag shows up only in the next poll reply, which is one byte long, so a reply can never collide with a stream of incoming data of unknown length. The first reply waits until a quiet interval, counted in clock cycles, has passed since reset.

The controller is a four-state machine. ST_SILENT leaves the output passive. It moves to ST_WAIT_QUIET when any byte arrives. ST_WAIT_QUIET moves to ST_LISTEN once the quiet interval has elapsed. ST_LISTEN moves to ST_REPLY when an enquiry is pending, and the reply byte is loaded on that transition. ST_REPLY returns to ST_LISTEN when the transmitter accepts the byte.

Top module: `boot_poll_responder`

## Requirements
- R1: Reset (rst_n low) sets tx_oe and tx_valid to 0 and clears the sticky error flag and any pending enquiry. After reset, a non-enquiry byte produces no reply, and the next enquiry gets 8'hFE.
- R2: tx_oe stays 0 until a byte of any value has been accepted (rx_valid high at a clock edge). It is 1 from the following edge until reset.
- R3: No reply is presented (tx_valid) before QUIET_CYCLES clock edges have passed since reset release. An enquiry that arrives earlier is held and answered afterwards.
- R4: Only the byte values 8'hFE and 8'hFF are enquiries. Any other byte value produces no reply.
- R5: The reply byte is 8'hFE when no error strobe has been seen since the previous reply was loaded, and 8'hFF otherwise.
- R6: Any set bit of err_in at a clock edge sets the sticky error flag. The flag clears on the edge where a reply byte is loaded. An error strobe on that same edge is kept for the next reply.
- R7: tx_valid stays high with tx_data unchanged until tx_ready is high at a clock edge. Each enquiry yields exactly one reply byte.
- R8: An enquiry that arrives while a reply is waiting or being sent is held as pending and answered after the current byte is accepted. Several such enquiries collapse into one reply.
- R9: Once online and idle, an enquiry accepted at edge k raises tx_valid at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| err_in | input | N_ERR | Error strobes from decoder and parser |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |
| tx_valid | output | 1 | Reply byte is offered |
| tx_data | output | 8 | Reply status byte |
| tx_oe | output | 1 | Transmit pin drive enable (0 = passive) |

## Verification
Two functions can land in the same cycle here. One is an error strobe arriving on the edge where the reply byte is loaded and the sticky flag is cleared. The other is an enquiry arriving while the transmitter is stalled. The bench provokes the first by timing err_in to the load edge. It expects the current reply to be 8'hFE and the next reply to be 8'hFF. It provokes the second by holding tx_ready low and sending two enquiries, then expects exactly one extra reply after the stall ends, followed by silence. Random traffic mixes data bytes, error strobes and transmitter stalls, and each reply is checked against an error flag the bench keeps itself.

// File: rtl/boot_poll_pkg.sv
package boot_poll_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] POLL_CODE_A = 8'hFE;
    localparam logic [BYTE_W-1:0] POLL_CODE_B = 8'hFF;
    localparam logic [BYTE_W-1:0] REPLY_OK    = 8'hFE;
    localparam logic [BYTE_W-1:0] REPLY_ERR   = 8'hFF;

    typedef enum logic [1:0] {
        ST_SILENT     = 2'd0,
        ST_WAIT_QUIET = 2'd1,
        ST_LISTEN     = 2'd2,
        ST_REPLY      = 2'd3
    } boot_state_t;
endpackage

// File: rtl/boot_quiet_timer.sv
module boot_quiet_timer #(
    parameter int unsigned QUIET_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(QUIET_CYCLES + 2);

    generate
        if (QUIET_CYCLES == 0) begin : g_none
            assign done = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q != CW'(QUIET_CYCLES)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign done = (cnt_q == CW'(QUIET_CYCLES));
        end
    endgenerate
endmodule

// File: rtl/boot_poll_detect.sv
module boot_poll_detect
    import boot_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              consume,
    output logic              pending
);
    logic is_poll;
    logic hit;

    always_comb begin
        is_poll = (rx_data == POLL_CODE_A) || (rx_data == POLL_CODE_B);
        hit     = rx_valid && is_poll;
    end

    // a new enquiry on the consume edge stays pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= hit || (pending && !consume);
        end
    end
endmodule

// File: rtl/boot_err_latch.sv
module boot_err_latch #(
    parameter int N_ERR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] err_in,
    input  logic             consume,
    output logic             flag
);
    logic any_err;

    always_comb begin
        any_err = |err_in;
    end

    // set wins over clear so an error on the load edge is not lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= any_err || (flag && !consume);
        end
    end
endmodule

// File: rtl/boot_poll_responder.sv
module boot_poll_responder
    import boot_poll_pkg::*;
#(
    parameter int unsigned QUIET_CYCLES = 1250000,
    parameter int          N_ERR        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [N_ERR-1:0]  err_in,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_oe
);
    boot_state_t       state_q, state_d;
    logic              quiet_done;
    logic              pending;
    logic              err_flag;
    logic              load;
    logic [BYTE_W-1:0] reply_q;

    boot_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (quiet_done)
    );

    boot_poll_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .consume  (load),
        .pending  (pending)
    );

    boot_err_latch #(.N_ERR(N_ERR)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_in  (err_in),
        .consume (load),
        .flag    (err_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SILENT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SILENT:     if (rx_valid)   state_d = ST_WAIT_QUIET;
            ST_WAIT_QUIET: if (quiet_done) state_d = ST_LISTEN;
            ST_LISTEN:     if (pending)    state_d = ST_REPLY;
            ST_REPLY:      if (tx_ready)   state_d = ST_LISTEN;
            default:                       state_d = ST_SILENT;
        endcase
    end

    always_comb begin
        tx_oe    = 1'b1;
        tx_valid = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            ST_SILENT:     tx_oe    = 1'b0;
            ST_WAIT_QUIET: tx_oe    = 1'b1;
            ST_LISTEN:     load     = pending;
            ST_REPLY:      tx_valid = 1'b1;
            default:       tx_oe    = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reply_q <= REPLY_OK;
        end else if (load) begin
            reply_q <= err_flag ? REPLY_ERR : REPLY_OK;
        end
    end

    assign tx_data = reply_q;
endmodule

// File: rtl/boot_poll_responder_chk.sv
module boot_poll_responder_chk #(
    parameter int unsigned QUIET_CYCLES = 1250000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       tx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_oe
);
    localparam int CW = $clog2(QUIET_CYCLES + 2);
    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != CW'(QUIET_CYCLES)) begin
            since_q <= since_q + 1'b1;
        end
    end

    assert_oe_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> $past(rx_valid));

    assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |=> tx_oe);

    assert_valid_online_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_oe);

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (since_q == CW'(QUIET_CYCLES)));

    assert_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data == 8'hFE || tx_data == 8'hFF));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind boot_poll_responder boot_poll_responder_chk #(.QUIET_CYCLES(QUIET_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_oe    (tx_oe)
);

// File: tb/boot_poll_responder_test.sv
module boot_poll_responder_test;
    localparam int unsigned QUIET = 40;
    localparam int          NERR  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_data = 8'h00;
    logic [NERR-1:0] err_in = '0;
    logic            tx_ready = 1'b0;
    logic            tx_valid;
    logic [7:0]      tx_data;
    logic            tx_oe;

    int vectors = 0;
    int fails = 0;
    bit err_m = 1'b0;
    logic [31:0] since_rst;

    always #4 clk = ~clk;

    boot_poll_responder #(.QUIET_CYCLES(QUIET), .N_ERR(NERR)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .err_in   (err_in),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_oe    (tx_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 32'd0;
        else        since_rst <= since_rst + 32'd1;
    end

    function automatic logic [7:0] exp_reply(input bit e);
        return e ? 8'hFF : 8'hFE;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [NERR-1:0] e);
        rx_valid = 1'b1;
        rx_data  = b;
        err_in   = e;
        @(negedge clk);
        rx_valid = 1'b0;
        err_in   = '0;
    endtask

    task automatic no_reply_for(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (tx_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, req, {31'd0, seen}, 32'd0);
    endtask

    task automatic take_reply(input logic [7:0] exp, input string req, input int stall);
        int w = 0;
        logic [7:0] d;
        while (!tx_valid && w < 200) begin
            @(negedge clk);
            w++;
        end
        chk(tx_valid, {req, " reply present"}, {31'd0, tx_valid}, 32'd1);
        d = tx_data;
        chk(d == exp, req, {24'd0, d}, {24'd0, exp});
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == d, "R7 hold during stall", {23'd0, tx_valid, tx_data}, {23'd1, d});
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx_oe == 1'b0 && tx_valid == 1'b0, "R1 reset outputs", {30'd0, tx_oe, tx_valid}, 32'd0);
        idle(3);
        chk(tx_oe == 1'b0, "R2 passive before input", {31'd0, tx_oe}, 32'd0);

        // R2/R3: early enquiry held until quiet time passes
        send_byte(8'hFF, '0);
        chk(tx_oe == 1'b1, "R2 online after byte", {31'd0, tx_oe}, 32'd1);
        chk(tx_valid == 1'b0, "R3 no early reply", {31'd0, tx_valid}, 32'd0);
        while (!tx_valid && since_rst < 200) @(negedge clk);
        chk(since_rst >= QUIET, "R3 quiet interval", since_rst, QUIET);
        take_reply(8'hFE, "R3 held enquiry answered", 0);
        chk(tx_valid == 1'b0, "R7 one byte per enquiry", {31'd0, tx_valid}, 32'd0);

        // R4 non-enquiry bytes
        send_byte(8'h41, '0);
        send_byte(8'hFD, '0);
        no_reply_for(20, "R4 non-enquiry ignored");

        // R9 latency
        send_byte(8'hFE, '0);
        chk(tx_valid == 1'b0, "R9 not yet", {31'd0, tx_valid}, 32'd0);
        @(negedge clk);
        chk(tx_valid == 1'b1, "R9 next edge", {31'd0, tx_valid}, 32'd1);
        take_reply(8'hFE, "R9 reply", 0);

        // R5/R6 sticky error then clear
        err_in = 2'b10;
        @(negedge clk);
        err_in = '0;
        idle(3);
        send_byte(8'hFE, '0);
        take_reply(8'hFF, "R5 error reported", 1);
        send_byte(8'hFF, '0);
        take_reply(8'hFE, "R6 flag cleared by reply", 0);

        // R6 error on the load edge kept for the next reply
        send_byte(8'hFE, '0);
        err_in = 2'b01;
        @(negedge clk);
        err_in = '0;
        chk(tx_valid == 1'b1, "R6 load edge", {31'd0, tx_valid}, 32'd1);
        take_reply(8'hFE, "R6 current reply excludes load-edge error", 0);
        send_byte(8'hFE, '0);
        take_reply(8'hFF, "R6 load-edge error in next reply", 0);

        // R8 enquiries during stall collapse to one
        send_byte(8'hFF, '0);
        @(negedge clk);
        chk(tx_valid == 1'b1, "R8 first reply up", {31'd0, tx_valid}, 32'd1);
        send_byte(8'hFE, '0);
        send_byte(8'hFF, '0);
        chk(tx_valid == 1'b1 && tx_data == 8'hFE, "R8 stalled reply held", {23'd0, tx_valid, tx_data}, {23'd1, 8'hFE});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        take_reply(8'hFE, "R8 pending enquiry answered", 0);
        no_reply_for(10, "R8 collapsed to one reply");

        // random traffic
        for (int i = 0; i < 150; i++) begin
            int nb = $urandom_range(0, 3);
            logic [NERR-1:0] e;
            for (int j = 0; j < nb; j++) begin
                logic [7:0] b = 8'($urandom_range(0, 253));
                e = ($urandom_range(0, 3) == 0) ? NERR'($urandom_range(1, 3)) : '0;
                send_byte(b, e);
                if (e != '0) err_m = 1'b1;
                chk(tx_valid == 1'b0, "R4 random data no reply", {31'd0, tx_valid}, 32'd0);
            end
            e = ($urandom_range(0, 4) == 0) ? NERR'($urandom_range(1, 3)) : '0;
            if (e != '0) err_m = 1'b1;
            send_byte(($urandom_range(0, 1) == 1) ? 8'hFF : 8'hFE, e);
            take_reply(exp_reply(err_m), "R5 random reply", $urandom_range(0, 3));
            err_m = 1'b0;
            chk(tx_valid == 1'b0, "R7 random single reply", {31'd0, tx_valid}, 32'd0);
            idle($urandom_range(0, 2));
        end

        // R1 reset in mid-operation clears error and pending
        err_in = 2'b11;
        @(negedge clk);
        err_in = '0;
        rx_valid = 1'b1;
        rx_data  = 8'hFE;
        @(negedge clk);
        rx_valid = 1'b0;
        rst_n = 1'b0;
        idle(2);
        chk(tx_oe == 1'b0 && tx_valid == 1'b0, "R1 reset passive", {30'd0, tx_oe, tx_valid}, 32'd0);
        rst_n = 1'b1;
        idle(QUIET + 5);
        chk(tx_oe == 1'b0, "R1 still passive after reset", {31'd0, tx_oe}, 32'd0);
        send_byte(8'h10, '0);
        no_reply_for(20, "R1 pending cleared");
        send_byte(8'hFF, '0);
        take_reply(8'hFE, "R1 error cleared", 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule